// File: doc/BRIEF.md
# Serial Frame Receiver with Ready-to-Send Flow Control

This block receives asynchronous serial frames on a single data line. After the receive-enable control is set, a falling edge on the line is taken as a start bit. The block checks the start bit again at its midpoint and then samples each data bit at the middle of its bit period. Bit timing comes from a 16x oversampling clock-enable input. Data bits arrive least significant bit first. Each one enters the top of a shift register, which moves right by one place. Once the selected number of bits has been shifted in, the word is copied into a 16-bit receive buffer, right-aligned with the upper bits zero, and a receive-complete flag is raised.

Software reads the buffer and signals the read with a one-cycle strobe on the low byte. This strobe clears the receive-complete and overrun flags. A level interrupt request can be raised on each completed word, or suppressed by a mode input. An active-low ready-to-send output provides flow control towards the remote transmitter's clear-to-send input. It goes low when reception is switched on or the buffer is read. It goes high again as soon as a new start bit is seen. A remote sender that honours this line therefore never overwrites an unread word.

Top module: `uart_rx_rts`

## Requirements
- R1: Frames are received only while `rx_en` is 1. A start edge is ignored while it is 0. Clearing it in the middle of a frame abandons that frame, so no word completes and `rx_done` stays 0.
- R2: A 1-to-0 transition of the synchronized line starts a frame. If the line is high again at the eighth `os_tick` after the edge, the start is treated as noise and nothing is received.
- R3: Each data bit is sampled every 16 `os_tick` pulses after the start-bit midpoint, least significant bit first. Bit timing counts only `os_tick` pulses, so a slower tick rate gives the same word.
- R4: `len_sel` sets the data length: 0 = 7 bits, 1 = 8 bits, 2 = 9 bits, 3 = 8 bits. `rd_data` holds the received bits at bit 0 upward, and every bit above the data length is 0.
- R5: When a word moves into the buffer, `rx_done` becomes 1 on the next clock and `rd_data` shows the new word.
- R6: A one-cycle `rd_lo` pulse clears `rx_done` and `overrun` on the next clock. If a word completes in that same cycle, `rx_done` stays 1.
- R7: With `irq_mode` = 0, each completed word sets `irq_req`. With `irq_mode` = 1, `irq_req` is not set. `irq_clr` clears `irq_req`.
- R8: `rts_n` is 1 whenever `rts_en` is 0. With `rts_en` = 1, `rts_n` goes to 0 after `rx_en` changes from 0 to 1, or after an `rd_lo` pulse. It goes to 1 on the clock after a start edge is detected, and stays 1 until the next `rd_lo`.
- R9: If a word completes while `rx_done` is still 1 and no read happens in that cycle, `overrun` becomes 1 and `rd_data` is replaced by the newer word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| os_tick | input | 1 | Clock enable at 16 times the bit rate |
| rx_en | input | 1 | Receive enable |
| len_sel | input | 2 | Data length select (0 = 7, 1 = 8, 2 = 9, 3 = 8 bits) |
| irq_mode | input | 1 | 0 = raise an interrupt request on each word, 1 = no request |
| irq_clr | input | 1 | Clears the interrupt request |
| rts_en | input | 1 | Enables ready-to-send control on `rts_n` |
| rd_lo | input | 1 | One-cycle strobe: low byte of the buffer was read |
| rxd | input | 1 | Serial data line, idles high |
| rd_data | output | 16 | Receive buffer, zero-extended |
| rx_done | output | 1 | Receive-complete flag |
| overrun | output | 1 | A word was overwritten before it was read |
| irq_req | output | 1 | Interrupt request |
| rts_n | output | 1 | Ready to send, active low |

## Verification
A bit counter that is off by one shows up in `rd_data` as soon as the frame ends. The word is shifted by one place, or it holds a stop-bit 1 above the selected length. An early or late sampling point produces wrong bit values within a single frame once a pattern with alternating bits is sent. A flow-control state that misses the start event or the read event is visible on `rts_n`. The first case shows in the middle of the start bit, and the second one clock after the read strobe. A flag register that ignores a read, or ignores a completion that overlaps an unread word, shows on `rx_done` or `overrun` one clock after that event.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_e;

    // Data length in bits for the length-select code.
    function automatic int data_len(input logic [1:0] sel);
        case (sel)
            2'd0:    return 7;
            2'd2:    return 9;
            default: return 8;
        endcase
    endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sync_d, sync_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sync_d = din;
        end else begin : g_chain
            always_comb sync_d = {sync_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign dout = sync_q[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int OS_RATE  = 16,
    parameter int MAX_BITS = 9,
    localparam int CNT_W   = $clog2(OS_RATE),
    localparam int BIT_W   = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                os_tick,
    input  logic                rx_en,
    input  logic                rxd_s,
    input  logic [BIT_W-1:0]    nbits,
    output logic                start_o,
    output logic                xfer_o,
    output logic [MAX_BITS-1:0] data_o
);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OS_RATE - 1);
    localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(OS_RATE / 2 - 1);

    typedef struct packed {
        rx_state_e           state;
        logic [CNT_W-1:0]    cnt;
        logic [BIT_W-1:0]    bitn;
        logic [MAX_BITS-1:0] shreg;
        logic                prev;
    } frame_t;

    frame_t fr_d, fr_q;
    logic [BIT_W-1:0] shift_amt;

    always_comb begin
        fr_d      = fr_q;
        start_o   = 1'b0;
        xfer_o    = 1'b0;
        fr_d.prev = rxd_s;
        if (!rx_en) begin
            fr_d.state = RX_IDLE;
            fr_d.cnt   = '0;
            fr_d.bitn  = '0;
        end else begin
            case (fr_q.state)
                RX_IDLE: begin
                    if (fr_q.prev && !rxd_s) begin
                        fr_d.state = RX_START;
                        fr_d.cnt   = '0;
                        start_o    = 1'b1;
                    end
                end
                RX_START: begin
                    if (os_tick) begin
                        if (fr_q.cnt == CNT_HALF) begin
                            fr_d.cnt  = '0;
                            fr_d.bitn = '0;
                            fr_d.state = rxd_s ? RX_IDLE : RX_DATA;
                        end else begin
                            fr_d.cnt = fr_q.cnt + 1'b1;
                        end
                    end
                end
                RX_DATA: begin
                    if (os_tick) begin
                        if (fr_q.cnt == CNT_LAST) begin
                            fr_d.cnt   = '0;
                            fr_d.shreg = {rxd_s, fr_q.shreg[MAX_BITS-1:1]};
                            if (fr_q.bitn == nbits - 1'b1) begin
                                xfer_o     = 1'b1;
                                fr_d.state = RX_STOP;
                            end else begin
                                fr_d.bitn = fr_q.bitn + 1'b1;
                            end
                        end else begin
                            fr_d.cnt = fr_q.cnt + 1'b1;
                        end
                    end
                end
                RX_STOP: begin
                    if (os_tick) begin
                        if (fr_q.cnt == CNT_LAST) fr_d.state = RX_IDLE;
                        else                      fr_d.cnt   = fr_q.cnt + 1'b1;
                    end
                end
                default: fr_d.state = RX_IDLE;
            endcase
        end
        shift_amt = BIT_W'(MAX_BITS) - nbits;
        data_o    = fr_d.shreg >> shift_amt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q       <= '0;
            fr_q.state <= RX_IDLE;
            fr_q.prev  <= 1'b1;
        end else begin
            fr_q <= fr_d;
        end
    end

    AST_NO_RX_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |-> (!xfer_o && !start_o)); // R1
    AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> (fr_q.state == RX_START)); // R2
endmodule

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl #(
    parameter int MAX_BITS = 9,
    parameter int BUF_W    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_en,
    input  logic                rts_en,
    input  logic                irq_mode,
    input  logic                irq_clr,
    input  logic                rd_lo,
    input  logic                start_i,
    input  logic                xfer_i,
    input  logic [MAX_BITS-1:0] data_i,
    output logic [BUF_W-1:0]    buf_o,
    output logic                done_o,
    output logic                ovr_o,
    output logic                irq_o,
    output logic                rts_n_o
);
    typedef struct packed {
        logic [BUF_W-1:0] rbuf;
        logic             done;
        logic             ovr;
        logic             irq;
        logic             ready;
        logic             en_prev;
    } ctl_t;

    ctl_t ct_d, ct_q;

    always_comb begin
        ct_d         = ct_q;
        ct_d.en_prev = rx_en;
        if (rd_lo) begin
            ct_d.done  = 1'b0;
            ct_d.ovr   = 1'b0;
            ct_d.ready = 1'b1;
        end
        if (rx_en && !ct_q.en_prev) ct_d.ready = 1'b1;
        if (start_i)                ct_d.ready = 1'b0;
        if (irq_clr)                ct_d.irq   = 1'b0;
        if (xfer_i) begin
            ct_d.rbuf = BUF_W'(data_i);
            ct_d.done = 1'b1;
            if (ct_q.done && !rd_lo) ct_d.ovr = 1'b1;
            if (!irq_mode)           ct_d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ct_q <= '0;
        else        ct_q <= ct_d;
    end

    assign buf_o   = ct_q.rbuf;
    assign done_o  = ct_q.done;
    assign ovr_o   = ct_q.ovr;
    assign irq_o   = ct_q.irq;
    assign rts_n_o = ~(rts_en & ct_q.ready);

    AST_DONE_AFTER_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_i |=> done_o); // R5
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lo && !xfer_i) |=> (!done_o && !ovr_o)); // R6
    AST_IRQ_ON_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_i && !irq_mode) |=> irq_o); // R7
    AST_RTS_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> rts_n_o); // R8
    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_i && done_o && !rd_lo) |=> ovr_o); // R9
endmodule

// File: rtl/uart_rx_rts.sv
module uart_rx_rts
    import uart_rx_pkg::*;
#(
    parameter int OS_RATE     = 16,
    parameter int MAX_BITS    = 9,
    parameter int BUF_W       = 16,
    parameter int SYNC_STAGES = 2,
    localparam int BIT_W      = $clog2(MAX_BITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             os_tick,
    input  logic             rx_en,
    input  logic [1:0]       len_sel,
    input  logic             irq_mode,
    input  logic             irq_clr,
    input  logic             rts_en,
    input  logic             rd_lo,
    input  logic             rxd,
    output logic [BUF_W-1:0] rd_data,
    output logic             rx_done,
    output logic             overrun,
    output logic             irq_req,
    output logic             rts_n
);
    logic                rxd_s;
    logic                start_ev;
    logic                xfer_ev;
    logic [MAX_BITS-1:0] word;
    logic [BIT_W-1:0]    nbits;

    assign nbits = BIT_W'(data_len(len_sel));

    uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd),
        .dout (rxd_s)
    );

    uart_rx_frame #(.OS_RATE(OS_RATE), .MAX_BITS(MAX_BITS)) u_frame (
        .clk    (clk),
        .rst_n  (rst_n),
        .os_tick(os_tick),
        .rx_en  (rx_en),
        .rxd_s  (rxd_s),
        .nbits  (nbits),
        .start_o(start_ev),
        .xfer_o (xfer_ev),
        .data_o (word)
    );

    uart_rx_ctrl #(.MAX_BITS(MAX_BITS), .BUF_W(BUF_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_en   (rx_en),
        .rts_en  (rts_en),
        .irq_mode(irq_mode),
        .irq_clr (irq_clr),
        .rd_lo   (rd_lo),
        .start_i (start_ev),
        .xfer_i  (xfer_ev),
        .data_i  (word),
        .buf_o   (rd_data),
        .done_o  (rx_done),
        .ovr_o   (overrun),
        .irq_o   (irq_req),
        .rts_n_o (rts_n)
    );
endmodule

// File: tb/tb_uart_rx_rts.sv
module tb_uart_rx_rts;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        os_tick = 1'b1;
    logic        rx_en = 1'b0;
    logic [1:0]  len_sel = 2'd1;
    logic        irq_mode = 1'b0;
    logic        irq_clr = 1'b0;
    logic        rts_en = 1'b0;
    logic        rd_lo = 1'b0;
    logic        rxd = 1'b1;
    logic [15:0] rd_data;
    logic        rx_done, overrun, irq_req, rts_n;

    int total = 0;
    int bad = 0;
    int tick_div = 1;
    logic rts_mid;

    always #10 clk = ~clk;

    uart_rx_rts dut (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_en(rx_en),
        .len_sel(len_sel), .irq_mode(irq_mode), .irq_clr(irq_clr),
        .rts_en(rts_en), .rd_lo(rd_lo), .rxd(rxd), .rd_data(rd_data),
        .rx_done(rx_done), .overrun(overrun), .irq_req(irq_req), .rts_n(rts_n)
    );

    initial begin : tick_gen
        int c;
        c = 0;
        forever begin
            @(negedge clk);
            c = (c + 1) % tick_div;
            os_tick = (c == 0);
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input int value, input int nb);
        int per;
        per = 16 * tick_div;
        rxd = 1'b0;
        wait_clk(per * 3 / 4);
        rts_mid = rts_n;
        wait_clk(per - per * 3 / 4);
        for (int i = 0; i < nb; i++) begin
            rxd = value[i];
            wait_clk(per);
        end
        rxd = 1'b1;
        wait_clk(per + 6);
    endtask

    task automatic do_read();
        rd_lo = 1'b1;
        wait_clk(1);
        rd_lo = 1'b0;
    endtask

    task automatic t_reset();
        chk(rx_done == 1'b0, "R5 reset done", rx_done, 0);
        chk(overrun == 1'b0, "R9 reset overrun", overrun, 0);
        chk(irq_req == 1'b0, "R7 reset irq", irq_req, 0);
        chk(rd_data == 16'h0, "R4 reset data", rd_data, 0);
        chk(rts_n == 1'b1, "R8 reset rts", rts_n, 1);
    endtask

    task automatic t_basic();
        rx_en = 1'b1;
        wait_clk(2);
        chk(rts_n == 1'b1, "R8 rts off when disabled", rts_n, 1);
        rts_en = 1'b1;
        wait_clk(1);
        chk(rts_n == 1'b0, "R8 rts low after enable", rts_n, 0);
        send_frame(32'hA5, 8);
        chk(rts_mid == 1'b1, "R8 rts high at start", rts_mid, 1);
        chk(rx_done == 1'b1, "R5 done set", rx_done, 1);
        chk(rd_data == 16'h00A5, "R3 data 8 bit", rd_data, 16'hA5);
        chk(irq_req == 1'b1, "R7 irq set", irq_req, 1);
        chk(rts_n == 1'b1, "R8 rts held until read", rts_n, 1);
        do_read();
        chk(rx_done == 1'b0, "R6 read clears done", rx_done, 0);
        chk(rts_n == 1'b0, "R8 rts low after read", rts_n, 0);
        irq_clr = 1'b1;
        wait_clk(1);
        irq_clr = 1'b0;
        chk(irq_req == 1'b0, "R7 irq cleared", irq_req, 0);
    endtask

    task automatic t_irq_off();
        irq_mode = 1'b1;
        send_frame(32'h3C, 8);
        chk(rx_done == 1'b1, "R7 done with irq off", rx_done, 1);
        chk(irq_req == 1'b0, "R7 no irq in mode 1", irq_req, 0);
        chk(rd_data == 16'h003C, "R3 data second pattern", rd_data, 16'h3C);
        do_read();
        irq_mode = 1'b0;
    endtask

    task automatic t_len7();
        len_sel = 2'd0;
        send_frame(32'h5A, 7);
        chk(rd_data == 16'h005A, "R4 seven bit word", rd_data, 16'h5A);
        do_read();
        len_sel = 2'd3;
        send_frame(32'hC3, 8);
        chk(rd_data == 16'h00C3, "R4 code 3 is eight bit", rd_data, 16'hC3);
        do_read();
    endtask

    task automatic t_len9_slow();
        len_sel = 2'd2;
        tick_div = 2;
        wait_clk(2);
        send_frame(32'h1C3, 9);
        chk(rd_data == 16'h01C3, "R3 R4 nine bit at half tick rate", rd_data, 16'h1C3);
        tick_div = 1;
        do_read();
        len_sel = 2'd1;
    endtask

    task automatic t_overrun();
        send_frame(32'h11, 8);
        chk(overrun == 1'b0, "R9 no overrun on first", overrun, 0);
        send_frame(32'h22, 8);
        chk(rts_mid == 1'b1, "R8 rts stays high unread", rts_mid, 1);
        chk(overrun == 1'b1, "R9 overrun set", overrun, 1);
        chk(rd_data == 16'h0022, "R9 newer word kept", rd_data, 16'h22);
        do_read();
        chk(overrun == 1'b0, "R6 read clears overrun", overrun, 0);
    endtask

    task automatic t_glitch();
        rxd = 1'b0;
        wait_clk(4);
        rxd = 1'b1;
        wait_clk(60);
        chk(rx_done == 1'b0, "R2 short pulse ignored", rx_done, 0);
        send_frame(32'h81, 8);
        chk(rd_data == 16'h0081, "R2 frame after noise", rd_data, 16'h81);
        do_read();
    endtask

    task automatic t_disabled();
        rx_en = 1'b0;
        wait_clk(2);
        send_frame(32'h00, 8);
        chk(rx_done == 1'b0, "R1 no frame when disabled", rx_done, 0);
        rx_en = 1'b1;
        wait_clk(2);
        rxd = 1'b0;
        wait_clk(40);
        rx_en = 1'b0;
        wait_clk(20);
        rxd = 1'b1;
        wait_clk(200);
        chk(rx_done == 1'b0, "R1 aborted frame", rx_done, 0);
        chk(rd_data == 16'h0081, "R1 buffer kept", rd_data, 16'h81);
        rx_en = 1'b1;
        wait_clk(2);
        chk(rts_n == 1'b0, "R8 rts low on re-enable", rts_n, 0);
    endtask

    initial begin : watchdog
        #(20 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(2);
        t_reset();
        t_basic();
        t_irq_off();
        t_len7();
        t_len9_slow();
        t_overrun();
        t_glitch();
        t_disabled();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule